// File: doc/BRIEF.md
# Random-Access CMOS Sensor Frame Sequencer

This block produces every control strobe that a random-access CMOS pixel array needs to expose and read one frame, for a sensor with no internal timing generator. A single address bus is shared between row and column selection. Separate row-load and column-load strobes tell the sensor which register captures the bus. On a start request the sequencer first resets each row of a rectangular window, top to bottom. It then waits a programmed integration interval and reads the window back row by row. For each row it samples the integrated signal level and then the reset level. It then steps across the window's columns, firing a conversion for each pixel and capturing the 10-bit converter result.

All timing is in clock cycles and is latched from configuration inputs when the frame starts: strobe width, settling gap, integration interval and converter sampling delay. Captured pixels leave on a simple stream that carries a valid strobe, the data and the row and column coordinates. A one-cycle done flag marks the last pixel of the frame. The analog front end, gain setting and image storage are handled elsewhere.

Top module: `cmos_readout_seq`

## Requirements
- R1: While reset is asserted and right after it, every sensor strobe, `pix_valid` and `frame_done` are low.
- R2: A `start` pulse in idle latches the window and the four timing values. `start` pulses and configuration changes made during a frame have no effect on that frame's strobes, addresses or pixel stream.
- R3: The reset phase visits each window row in ascending order. It puts the row number on `sns_addr` with a `sns_row_ld` pulse, then gives a `sns_row_rst` pulse with the same address.
- R4: The readout row-load of any row starts at least `cfg_t_int` cycles after the end of that row's reset-phase reset pulse.
- R5: For each window row, in ascending order, readout issues `sns_row_ld`, `sns_samp_sig`, `sns_row_rst` and `sns_samp_rst` in exactly that order, each with the row number on `sns_addr`.
- R6: `sns_cal` is high together with `sns_samp_sig` on the first window row of a frame and never at any other time.
- R7: After the reset-level sample of a row, each window column is visited in ascending order. The column number is placed on `sns_addr` with a `sns_col_ld` pulse, then a `sns_conv` pulse follows. The address is held for the whole conversion, and no column outside the window is addressed.
- R8: Each strobe pulse stays high for exactly max(`cfg_t_pulse`,1) cycles. At most one of row-load, column-load, row-reset, signal-sample, reset-sample and conversion is high in any cycle.
- R9: `pix_valid` is high for one cycle, `cfg_t_settle`+max(`cfg_t_sample`,1) cycles after `sns_conv` falls. With it, `pix_data` carries the converter value of the addressed pixel, and `pix_row`/`pix_col` carry that pixel's coordinates.
- R10: `frame_done` is high for exactly one cycle per frame, in the same cycle as the last pixel's `pix_valid`.
- R11: Pixels leave in raster order, columns fastest, and the number of pixels equals the window area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| cfg_row_first | input | ADDR_W | First window row |
| cfg_row_last | input | ADDR_W | Last window row (>= first) |
| cfg_col_first | input | ADDR_W | First window column |
| cfg_col_last | input | ADDR_W | Last window column (>= first) |
| cfg_t_int | input | CNT_W | Integration interval in cycles |
| cfg_t_pulse | input | CNT_W | Strobe high time in cycles (0 acts as 1) |
| cfg_t_settle | input | CNT_W | Low gap after each strobe, may be 0 |
| cfg_t_sample | input | CNT_W | Converter sampling delay (0 acts as 1) |
| adc_data | input | PIX_W | Converter output from the sensor |
| sns_addr | output | ADDR_W | Shared row/column address bus |
| sns_row_ld | output | 1 | Row address load strobe |
| sns_col_ld | output | 1 | Column address load strobe |
| sns_row_rst | output | 1 | Row reset pulse |
| sns_samp_sig | output | 1 | Signal-level sample pulse |
| sns_samp_rst | output | 1 | Reset-level sample pulse |
| sns_cal | output | 1 | Black-reference calibration pulse |
| sns_conv | output | 1 | Conversion start pulse |
| pix_valid | output | 1 | Pixel stream valid |
| pix_data | output | PIX_W | Captured pixel value |
| pix_row | output | ADDR_W | Row of the captured pixel |
| pix_col | output | ADDR_W | Column of the captured pixel |
| frame_done | output | 1 | Last pixel of the frame |

## Verification
The bound checker watches the rules that hold on every cycle. Only one control strobe is active at a time, and calibration occurs only under the signal sample. Valid and done are single-cycle, done coincides with a valid pixel, and the address stays steady during a conversion. Ordering, window coverage, pulse widths and delays depend on the latched configuration, so only the bench's scenarios can show them. It logs every strobe edge across several windows and timing sets, including a single corner pixel and zero settling. It compares the log with an event list derived arithmetically from the window. It also models the sensor's address latches so that the captured data proves the correct row and column were selected.

// File: rtl/cmos_seq_pkg.sv
package cmos_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_LD,
    ST_RST_PUL,
    ST_INTEG,
    ST_RD_LD,
    ST_RD_S,
    ST_RD_RST,
    ST_RD_R,
    ST_COL_LD,
    ST_CONV,
    ST_SAMP
  } seq_state_e;

  // Steps that drive a strobe and may be followed by a settling gap
  function automatic logic is_strobe_step(seq_state_e s);
    return !(s inside {ST_IDLE, ST_INTEG, ST_SAMP});
  endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_m1;
  logic             cnt_en;

  assign len_m1  = (len == '0) ? '0 : len - 1'b1;
  assign expired = (cnt_q >= len_m1);
  assign cnt_en  = clr || !expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= clr ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/win_stepper.sv
module win_stepper #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] last,
  output logic [ADDR_W-1:0] val,
  output logic              at_end
);
  logic [ADDR_W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (load || adv) begin
      val_q <= load ? first : val_q + 1'b1;
    end
  end

  assign val    = val_q;
  assign at_end = (val_q == last);
endmodule

// File: rtl/cmos_readout_seq.sv
module cmos_readout_seq
  import cmos_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PIX_W  = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_row_first,
  input  logic [ADDR_W-1:0] cfg_row_last,
  input  logic [ADDR_W-1:0] cfg_col_first,
  input  logic [ADDR_W-1:0] cfg_col_last,
  input  logic [CNT_W-1:0]  cfg_t_int,
  input  logic [CNT_W-1:0]  cfg_t_pulse,
  input  logic [CNT_W-1:0]  cfg_t_settle,
  input  logic [CNT_W-1:0]  cfg_t_sample,
  input  logic [PIX_W-1:0]  adc_data,
  output logic [ADDR_W-1:0] sns_addr,
  output logic              sns_row_ld,
  output logic              sns_col_ld,
  output logic              sns_row_rst,
  output logic              sns_samp_sig,
  output logic              sns_samp_rst,
  output logic              sns_cal,
  output logic              sns_conv,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_data,
  output logic [ADDR_W-1:0] pix_row,
  output logic [ADDR_W-1:0] pix_col,
  output logic              frame_done
);
  seq_state_e st_q, st_d;
  logic gap_q, gap_d;

  logic [ADDR_W-1:0] row_first_q, row_last_q, col_first_q, col_last_q;
  logic [CNT_W-1:0]  t_int_q, t_pulse_q, t_settle_q, t_samp_q;

  logic              cfg_take, phase_end, tmr_clr, expired, step_done;
  logic [CNT_W-1:0]  tlen;
  logic              row_load, row_adv, col_load, col_adv, row_end, col_end;
  logic [ADDR_W-1:0] row_val, col_val, row_first_sel, col_first_sel;
  logic              cap, last_pix, strobe_on;

  logic              pix_valid_q, done_q;
  logic [PIX_W-1:0]  pix_data_q;
  logic [ADDR_W-1:0] pix_row_q, pix_col_q;

  // Window counters: start values bypass the config registers on the start cycle
  assign row_first_sel = cfg_take ? cfg_row_first : row_first_q;
  assign col_first_sel = cfg_take ? cfg_col_first : col_first_q;

  win_stepper #(.ADDR_W(ADDR_W)) i_row_step (
    .clk(clk), .rst_n(rst_n), .load(row_load), .adv(row_adv),
    .first(row_first_sel), .last(row_last_q), .val(row_val), .at_end(row_end)
  );

  win_stepper #(.ADDR_W(ADDR_W)) i_col_step (
    .clk(clk), .rst_n(rst_n), .load(col_load), .adv(col_adv),
    .first(col_first_sel), .last(col_last_q), .val(col_val), .at_end(col_end)
  );

  assign tmr_clr = phase_end || (st_q == ST_IDLE);

  step_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .len(tlen), .expired(expired)
  );

  // Next-state logic
  always_comb begin
    st_d      = st_q;
    gap_d     = gap_q;
    cfg_take  = 1'b0;
    phase_end = 1'b0;
    step_done = 1'b0;
    row_load  = 1'b0;
    row_adv   = 1'b0;
    col_load  = 1'b0;
    col_adv   = 1'b0;
    cap       = 1'b0;
    last_pix  = 1'b0;

    if (st_q == ST_INTEG)     tlen = t_int_q;
    else if (st_q == ST_SAMP) tlen = t_samp_q;
    else                      tlen = gap_q ? t_settle_q : t_pulse_q;

    if (st_q == ST_IDLE) begin
      if (start) begin
        cfg_take = 1'b1;
        row_load = 1'b1;
        st_d     = ST_RST_LD;
      end
    end else if (expired) begin
      if (is_strobe_step(st_q) && !gap_q && (t_settle_q != '0)) begin
        gap_d     = 1'b1;
        phase_end = 1'b1;
      end else begin
        gap_d     = 1'b0;
        phase_end = 1'b1;
        step_done = 1'b1;
      end
    end

    if (step_done) begin
      unique case (st_q)
        ST_RST_LD:  st_d = ST_RST_PUL;
        ST_RST_PUL: begin
          if (row_end) begin
            row_load = 1'b1;
            st_d     = ST_INTEG;
          end else begin
            row_adv = 1'b1;
            st_d    = ST_RST_LD;
          end
        end
        ST_INTEG:   st_d = ST_RD_LD;
        ST_RD_LD:   st_d = ST_RD_S;
        ST_RD_S:    st_d = ST_RD_RST;
        ST_RD_RST:  st_d = ST_RD_R;
        ST_RD_R: begin
          col_load = 1'b1;
          st_d     = ST_COL_LD;
        end
        ST_COL_LD:  st_d = ST_CONV;
        ST_CONV:    st_d = ST_SAMP;
        ST_SAMP: begin
          cap = 1'b1;
          if (!col_end) begin
            col_adv = 1'b1;
            st_d    = ST_COL_LD;
          end else if (!row_end) begin
            row_adv = 1'b1;
            st_d    = ST_RD_LD;
          end else begin
            last_pix = 1'b1;
            st_d     = ST_IDLE;
          end
        end
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  // State and configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      gap_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      gap_q <= gap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_first_q <= '0;
      row_last_q  <= '0;
      col_first_q <= '0;
      col_last_q  <= '0;
      t_int_q     <= '0;
      t_pulse_q   <= '0;
      t_settle_q  <= '0;
      t_samp_q    <= '0;
    end else if (cfg_take) begin
      row_first_q <= cfg_row_first;
      row_last_q  <= cfg_row_last;
      col_first_q <= cfg_col_first;
      col_last_q  <= cfg_col_last;
      t_int_q     <= cfg_t_int;
      t_pulse_q   <= cfg_t_pulse;
      t_settle_q  <= cfg_t_settle;
      t_samp_q    <= cfg_t_sample;
    end
  end

  // Pixel capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_data_q <= '0;
      pix_row_q  <= '0;
      pix_col_q  <= '0;
    end else if (cap) begin
      pix_data_q <= adc_data;
      pix_row_q  <= row_val;
      pix_col_q  <= col_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      pix_valid_q <= cap;
      done_q      <= last_pix;
    end
  end

  // Sensor drive, decoded from registered state
  assign strobe_on    = is_strobe_step(st_q) && !gap_q;
  assign sns_row_ld   = strobe_on && (st_q == ST_RST_LD || st_q == ST_RD_LD);
  assign sns_row_rst  = strobe_on && (st_q == ST_RST_PUL || st_q == ST_RD_RST);
  assign sns_samp_sig = strobe_on && (st_q == ST_RD_S);
  assign sns_samp_rst = strobe_on && (st_q == ST_RD_R);
  assign sns_col_ld   = strobe_on && (st_q == ST_COL_LD);
  assign sns_conv     = strobe_on && (st_q == ST_CONV);
  assign sns_cal      = sns_samp_sig && (row_val == row_first_q);

  always_comb begin
    if (st_q inside {ST_COL_LD, ST_CONV, ST_SAMP})  sns_addr = col_val;
    else if (st_q inside {ST_IDLE, ST_INTEG})       sns_addr = '0;
    else                                            sns_addr = row_val;
  end

  assign pix_valid  = pix_valid_q;
  assign pix_data   = pix_data_q;
  assign pix_row    = pix_row_q;
  assign pix_col    = pix_col_q;
  assign frame_done = done_q;
endmodule

// File: rtl/cmos_readout_seq_chk.sv
module cmos_readout_seq_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sns_addr,
  input logic              sns_row_ld,
  input logic              sns_col_ld,
  input logic              sns_row_rst,
  input logic              sns_samp_sig,
  input logic              sns_samp_rst,
  input logic              sns_cal,
  input logic              sns_conv,
  input logic              pix_valid,
  input logic              frame_done
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sns_row_ld, sns_col_ld, sns_row_rst, sns_samp_sig, sns_samp_rst, sns_conv}))
    else $error("more than one strobe active"); // R8

  AST_CAL_UNDER_S: assert property (@(posedge clk) disable iff (!rst_n)
    sns_cal |-> sns_samp_sig)
    else $error("calibration outside signal sample"); // R6

  AST_CONV_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sns_conv && $past(sns_conv)) |-> $stable(sns_addr))
    else $error("address moved during conversion"); // R7

  AST_PIX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid)
    else $error("pixel valid longer than one cycle"); // R9

  AST_DONE_WITH_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> pix_valid)
    else $error("done without a pixel"); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done)
    else $error("done longer than one cycle"); // R10
endmodule

bind cmos_readout_seq cmos_readout_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .sns_addr(sns_addr),
  .sns_row_ld(sns_row_ld), .sns_col_ld(sns_col_ld), .sns_row_rst(sns_row_rst),
  .sns_samp_sig(sns_samp_sig), .sns_samp_rst(sns_samp_rst), .sns_cal(sns_cal),
  .sns_conv(sns_conv), .pix_valid(pix_valid), .frame_done(frame_done)
);

// File: tb/test_cmos_readout_seq.sv
module test_cmos_readout_seq;
  localparam int AW = 10;
  localparam int PW = 10;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] cfg_row_first = '0, cfg_row_last = '0, cfg_col_first = '0, cfg_col_last = '0;
  logic [CW-1:0] cfg_t_int = '0, cfg_t_pulse = '0, cfg_t_settle = '0, cfg_t_sample = '0;
  logic [PW-1:0] adc_data;
  logic [AW-1:0] sns_addr, pix_row, pix_col;
  logic sns_row_ld, sns_col_ld, sns_row_rst, sns_samp_sig, sns_samp_rst, sns_cal, sns_conv;
  logic pix_valid, frame_done;
  logic [PW-1:0] pix_data;

  always #10 clk = ~clk;

  cmos_readout_seq #(.ADDR_W(AW), .PIX_W(PW), .CNT_W(CW)) i_cmos_readout_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_row_first(cfg_row_first), .cfg_row_last(cfg_row_last),
    .cfg_col_first(cfg_col_first), .cfg_col_last(cfg_col_last),
    .cfg_t_int(cfg_t_int), .cfg_t_pulse(cfg_t_pulse),
    .cfg_t_settle(cfg_t_settle), .cfg_t_sample(cfg_t_sample),
    .adc_data(adc_data), .sns_addr(sns_addr),
    .sns_row_ld(sns_row_ld), .sns_col_ld(sns_col_ld), .sns_row_rst(sns_row_rst),
    .sns_samp_sig(sns_samp_sig), .sns_samp_rst(sns_samp_rst), .sns_cal(sns_cal),
    .sns_conv(sns_conv), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_row(pix_row), .pix_col(pix_col), .frame_done(frame_done)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pix_model(input int r, input int c);
    return (r * 7 + c * 13 + 3) % 1024;
  endfunction

  // Sensor model: address latches and converter output
  logic [AW-1:0] lat_row = '0;
  logic [AW-1:0] lat_col = '0;
  always @(posedge clk) begin
    if (sns_row_ld) lat_row <= sns_addr;
    if (sns_col_ld) lat_col <= sns_addr;
  end
  assign adc_data = PW'(pix_model(int'(lat_row), int'(lat_col)));

  // Frame configuration used by the monitor
  int f_rf, f_rl, f_cf, f_cl, f_tp, f_ts, f_tsm, f_ti, nrows, ncols;

  // Event codes: 1 row_ld, 2 row_rst, 3 samp_sig, 4 samp_rst, 5 cal, 6 col_ld, 7 conv
  int exp_code[512], exp_val[512], got_code[512], got_val[512];
  int n_exp, n_got;
  int cyc = 0;
  logic [6:0] prev = '0;
  int rise_t[7];
  int conv_fall;
  int rst_rise[1024];
  int rst_cnt, pix_idx, done_cnt;

  function automatic int code_of(input int i);
    case (i)
      0: return 1;  1: return 2;  2: return 3;  3: return 5;
      4: return 4;  5: return 6;  default: return 7;
    endcase
  endfunction

  always @(negedge clk) begin
    logic [6:0] cur;
    cyc++;
    cur = {sns_conv, sns_col_ld, sns_samp_rst, sns_cal, sns_samp_sig, sns_row_rst, sns_row_ld};
    if (rst_n) begin
      for (int i = 0; i < 7; i++) begin
        if (cur[i] && !prev[i]) begin
          rise_t[i] = cyc;
          if (n_got < 512) begin
            got_code[n_got] = code_of(i);
            got_val[n_got]  = int'(sns_addr);
          end
          n_got++;
          if (i == 1) begin
            if (rst_cnt < nrows) rst_rise[sns_addr] = cyc;
            rst_cnt++;
          end
          if (i == 0 && rst_cnt >= nrows)
            // R4: readout row-load vs end of that row's reset pulse
            chk(cyc - (rst_rise[sns_addr] + f_tp) >= f_ti, "R4", "integration gap",
                cyc - (rst_rise[sns_addr] + f_tp), f_ti);
        end
        if (!cur[i] && prev[i]) begin
          if (i != 3)
            chk(cyc - rise_t[i] == f_tp, "R8", "strobe width", cyc - rise_t[i], f_tp);
          if (i == 6) conv_fall = cyc;
        end
      end
      if (pix_valid) begin
        int er, ec;
        er = f_rf + pix_idx / ncols;
        ec = f_cf + pix_idx % ncols;
        chk(int'(pix_row) == er, "R11", "pixel row", int'(pix_row), er);
        chk(int'(pix_col) == ec, "R11", "pixel column", int'(pix_col), ec);
        chk(int'(pix_data) == pix_model(er, ec), "R9", "pixel data", int'(pix_data), pix_model(er, ec));
        chk(cyc - conv_fall == f_ts + f_tsm, "R9", "sample delay", cyc - conv_fall, f_ts + f_tsm);
        pix_idx++;
      end
      if (frame_done) begin
        done_cnt++;
        chk(pix_valid && pix_idx == nrows * ncols, "R10", "done with last pixel", pix_idx, nrows * ncols);
      end
    end
    prev = cur;
  end

  task automatic add_exp(input int code, input int val);
    exp_code[n_exp] = code;
    exp_val[n_exp]  = val;
    n_exp++;
  endtask

  task automatic run_frame(input int rf, input int rl, input int cf, input int cl,
                           input int tp, input int ts, input int tsm, input int ti);
    f_rf = rf; f_rl = rl; f_cf = cf; f_cl = cl;
    f_tp = (tp < 1) ? 1 : tp; f_ts = ts; f_tsm = (tsm < 1) ? 1 : tsm; f_ti = ti;
    nrows = rl - rf + 1;
    ncols = cl - cf + 1;
    n_exp = 0; n_got = 0; rst_cnt = 0; pix_idx = 0; done_cnt = 0;
    for (int r = rf; r <= rl; r++) begin
      add_exp(1, r); add_exp(2, r);
    end
    for (int r = rf; r <= rl; r++) begin
      add_exp(1, r); add_exp(3, r);
      if (r == rf) add_exp(5, r);
      add_exp(2, r); add_exp(4, r);
      for (int c = cf; c <= cl; c++) begin
        add_exp(6, c); add_exp(7, c);
      end
    end
    @(negedge clk);
    cfg_row_first = AW'(rf); cfg_row_last = AW'(rl);
    cfg_col_first = AW'(cf); cfg_col_last = AW'(cl);
    cfg_t_pulse = CW'(tp); cfg_t_settle = CW'(ts); cfg_t_sample = CW'(tsm); cfg_t_int = CW'(ti);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    // R2: disturb configuration and re-request start mid-frame
    cfg_row_first = '0; cfg_row_last = AW'(1023); cfg_col_first = '0; cfg_col_last = AW'(1023);
    cfg_t_pulse = CW'(9); cfg_t_settle = CW'(7); cfg_t_sample = CW'(5); cfg_t_int = CW'(3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 20000 && done_cnt == 0; w++) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(done_cnt == 1, "R10", "done pulses per frame", done_cnt, 1);
    chk(pix_idx == nrows * ncols, "R11", "pixel count", pix_idx, nrows * ncols);
    chk(n_got == n_exp, "R2", "strobe event count", n_got, n_exp);
    for (int k = 0; k < n_exp && k < n_got && k < 512; k++) begin
      string tag;
      if (k < 2 * nrows)                              tag = "R3";
      else if (exp_code[k] == 5 || got_code[k] == 5)  tag = "R6";
      else if (exp_code[k] >= 6)                      tag = "R7";
      else                                            tag = "R5";
      chk(got_code[k] == exp_code[k], tag, "event kind", got_code[k], exp_code[k]);
      chk(got_val[k] == exp_val[k], tag, "event address", got_val[k], exp_val[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk({sns_row_ld, sns_col_ld, sns_row_rst, sns_samp_sig, sns_samp_rst, sns_cal, sns_conv,
         pix_valid, frame_done} == '0, "R1", "outputs in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sns_row_ld, sns_col_ld, sns_row_rst, sns_samp_sig, sns_samp_rst, sns_cal, sns_conv,
         pix_valid, frame_done} == '0, "R1", "outputs after reset", 1, 0);
    run_frame(2, 4, 5, 8, 2, 1, 3, 20);
    run_frame(1023, 1023, 0, 0, 1, 0, 1, 0);
    run_frame(0, 1, 1021, 1023, 3, 2, 2, 5);
    run_frame(10, 12, 100, 101, 1, 0, 4, 40);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule